// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits, 8 by default, and returns the full `2W`-bit product. It takes several cycles and reuses one adder. A small controller drives a datapath with four registers: an accumulator, a multiplier register, a multiplicand register and an iteration counter. The adder is one bit wider than the operands so that no carry is lost. For each multiplier bit the controller adds the multiplicand to the accumulator if that bit is set. It then shifts the accumulator and the multiplier register right together as one register.

Before it iterates, the block finds the highest set bit of the multiplier. It runs only as many iterations as that bit position needs. A single final step then shifts the joined register right by the number of iterations it skipped. Small multipliers therefore finish sooner, and a zero multiplier completes at once. The user pulses `go`, holds the operands for one more cycle, and waits for the one-cycle `done` pulse.

Top module: `mulsa_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` becomes 0 and `prod` becomes 0.
- R2: When `done` is high, `prod` equals the unsigned product `opa * opb` of the operands that were loaded. For example, FFh times FFh gives FE01h, and 14 times 11 gives 154.
- R3: The operands are loaded on the clock edge that follows the edge that samples `go`. Changes to `opa` or `opb` after that edge have no effect on the result.
- R4: Each iteration first tests the low bit of the multiplier register. If the bit is 1, the controller spends one add cycle and then one shift cycle. If the bit is 0, it goes straight to the shift cycle.
- R5: Count the edge that samples `go` as edge 1. For a nonzero multiplier whose highest set bit is at index k and which has p set bits, `done` goes high after edge 3 + 2(k+1) + p.
- R6: A zero multiplier makes `done` go high after edge 2, with `prod` equal to 0.
- R7: `done` stays high for exactly one cycle. `prod` keeps its value until the next multiplication completes.
- R8: A `go` pulse that arrives while a multiplication is in progress is ignored. It starts no second operation and does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start request, sampled only while idle |
| opa | input | W | Multiplicand |
| opb | input | W | Multiplier |
| prod | output | 2W | Product, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the controller's branching on the multiplier low bit, that an add is always followed by a shift, that the block ignores `go` while busy, the fast completion for a zero multiplier, the one-cycle `done` pulse, that `prod` holds between completions, and an upper bound on how long a multiplication can run. Only the bench scenarios can show that the products are numerically correct across swept operands. The same holds for the exact latency formula as a function of the multiplier's bit pattern, and for the fact that late changes to the operands and stray `go` pulses leave the result untouched.

// File: rtl/mulsa_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes: nothing beyond the standard language.
package mulsa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INIT  = 3'd1,
        ST_TEST  = 3'd2,
        ST_ADD   = 3'd3,
        ST_SHIFT = 3'd4,
        ST_ALIGN = 3'd5
    } mulsa_state_t;
endpackage

// File: rtl/mulsa_lead_one.sv
// Finds the index of the highest set bit of a word.
// Assumes: the caller ignores idx when any_set is 0.
module mulsa_lead_one #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] idx,
    output logic          any_set
);
    // Priority scan: a higher set bit overrides a lower one.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) idx = CW'(i);
        end
    end

    // Flags a nonzero word.
    assign any_set = |val;
endmodule

// File: rtl/mulsa_ctrl.sv
// Controller: sequences load, test, add, shift and the final alignment.
// Assumes: q_lsb and last come from the datapath's registered state.
module mulsa_ctrl
    import mulsa_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         mplier_zero,
    input  logic         q_lsb,
    input  logic         last,
    output logic         ld,
    output logic         add_en,
    output logic         sh_en,
    output logic         align_en,
    output logic         zero_fin,
    output logic         done,
    output mulsa_state_t st
);
    mulsa_state_t st_d;

    // Next-state selection.
    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE:  if (go) st_d = ST_INIT;
            ST_INIT:  st_d = mplier_zero ? ST_IDLE : ST_TEST;
            ST_TEST:  st_d = q_lsb ? ST_ADD : ST_SHIFT;
            ST_ADD:   st_d = ST_SHIFT;
            ST_SHIFT: st_d = last ? ST_ALIGN : ST_TEST;
            ST_ALIGN: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Datapath strobes decoded from the current state.
    always_comb begin
        ld       = (st == ST_INIT);
        add_en   = (st == ST_ADD);
        sh_en    = (st == ST_SHIFT);
        align_en = (st == ST_ALIGN);
        zero_fin = (st == ST_INIT) && mplier_zero;
    end

    // State register and the registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_d;
            done <= align_en | zero_fin;
        end
    end
endmodule

// File: rtl/mulsa_dp.sv
// Datapath: accumulator, multiplier and multiplicand registers, a carry bit,
// a (W+1)-bit adder, the iteration counter and the product output register.
// Assumes: the controller asserts at most one strobe per cycle.
module mulsa_dp #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          add_en,
    input  logic          sh_en,
    input  logic          align_en,
    input  logic          zero_fin,
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    input  logic [CW-1:0] top_idx,
    output logic          q_lsb,
    output logic          last,
    output logic [2*W-1:0] prod
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] WC  = CW'(W);

    logic [W-1:0]  acc_q, mq_q, mc_q;
    logic          cy_q;
    logic [CW-1:0] cnt_q, iters_q;
    logic [W:0]    sum;
    logic [CW-1:0] skip;

    // Adder one bit wider than the operands keeps the carry.
    assign sum   = {1'b0, acc_q} + {1'b0, mc_q};
    // Number of iterations left out, and used for the final alignment.
    assign skip  = WC - iters_q;
    // Status flags for the controller.
    assign q_lsb = mq_q[0];
    assign last  = (cnt_q + ONE) == iters_q;

    // Working registers: load, accumulate, shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mq_q    <= '0;
            mc_q    <= '0;
            cy_q    <= 1'b0;
            cnt_q   <= '0;
            iters_q <= '0;
        end else if (ld) begin
            acc_q   <= '0;
            mq_q    <= mplier;
            mc_q    <= mcand;
            cy_q    <= 1'b0;
            cnt_q   <= '0;
            iters_q <= top_idx + ONE;
        end else if (add_en) begin
            acc_q <= sum[W-1:0];
            cy_q  <= sum[W];
        end else if (sh_en) begin
            acc_q <= {cy_q, acc_q[W-1:1]};
            mq_q  <= {acc_q[0], mq_q[W-1:1]};
            cy_q  <= 1'b0;
            cnt_q <= cnt_q + ONE;
        end
    end

    // Product register: aligned result on completion, zero for a zero multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (zero_fin) begin
            prod <= '0;
        end else if (align_en) begin
            prod <= {acc_q, mq_q} >> skip;
        end
    end
endmodule

// File: rtl/mulsa_top.sv
// Top level of the multi-cycle unsigned shift-add multiplier.
// Assumes: opa and opb are valid in the cycle after go is sampled.
module mulsa_top #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] prod,
    output logic           done
);
    localparam int CW = $clog2(W + 1);

    mulsa_pkg::mulsa_state_t st;
    logic [CW-1:0] top_idx;
    logic any_set, q_lsb, last;
    logic ld, add_en, sh_en, align_en, zero_fin;

    mulsa_lead_one #(.W(W), .CW(CW)) u_lead (
        .val(opb), .idx(top_idx), .any_set(any_set)
    );

    mulsa_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .mplier_zero(!any_set),
        .q_lsb(q_lsb), .last(last), .ld(ld), .add_en(add_en),
        .sh_en(sh_en), .align_en(align_en), .zero_fin(zero_fin),
        .done(done), .st(st)
    );

    mulsa_dp #(.W(W), .CW(CW)) u_dp (
        .clk(clk), .rst_n(rst_n), .ld(ld), .add_en(add_en), .sh_en(sh_en),
        .align_en(align_en), .zero_fin(zero_fin), .mcand(opa), .mplier(opb),
        .top_idx(top_idx), .q_lsb(q_lsb), .last(last), .prod(prod)
    );
endmodule

// File: rtl/mulsa_chk.sv
// Checker bound to mulsa_top: controller sequencing and output protocol.
// Assumes: the names st and q_lsb exist inside the top module.
module mulsa_chk
    import mulsa_pkg::*;
#(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   opb,
    input logic [2*W-1:0] prod,
    input logic           done,
    input mulsa_state_t   st,
    input logic           q_lsb
);
    localparam int MAXB = 3 * W + 3;
    int unsigned busy_cnt;

    // Counts the cycles spent away from idle in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_IDLE) busy_cnt <= 0;
        else busy_cnt <= busy_cnt + 1;
    end

    assert_lsb_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TEST && q_lsb) |=> st == ST_ADD);
    assert_lsb_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TEST && !q_lsb) |=> st == ST_SHIFT);
    assert_add_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ADD |=> st == ST_SHIFT);
    assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= MAXB);
    assert_zero_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_INIT && opb == '0) |=> (done && prod == '0));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_prod_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(prod));
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> st != ST_INIT);
endmodule

bind mulsa_top mulsa_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .opb(opb), .prod(prod), .done(done),
    .st(st), .q_lsb(q_lsb)
);

// File: tb/sim_mulsa_top.sv
// Directed bench for mulsa_top; each scenario task checks its own results.
module sim_mulsa_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [W-1:0] opa = '0, opb = '0;
    logic [2*W-1:0] prod;
    logic done;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mulsa_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .opa(opa), .opb(opb),
        .prod(prod), .done(done)
    );

    // Records one check and prints a line on mismatch.
    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected number of edges up to done (R5, R6).
    function automatic int exp_lat(input logic [W-1:0] b);
        int k = -1;
        for (int i = 0; i < W; i++) if (b[i]) k = i;
        if (k < 0) return 2;
        return 3 + 2 * (k + 1) + $countones(b);
    endfunction

    // Runs one multiplication and returns the product and edge count.
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           output int p, output int cyc);
        @(negedge clk); opa = a; opb = b; go = 1'b1;
        @(negedge clk); go = 1'b0; cyc = 1;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        p = int'(prod);
    endtask

    task automatic t_reset();
        chk("R1 done after reset", int'(done), 0);
        chk("R1 prod after reset", int'(prod), 0);
    endtask

    task automatic t_corners();
        int p, c;
        run_mul(8'hFF, 8'hFF, p, c); chk("R2 FF*FF", p, 16'hFE01);
        chk("R5 FF*FF latency", c, exp_lat(8'hFF));
        run_mul(8'd14, 8'd11, p, c); chk("R2 14*11", p, 154);
        run_mul(8'hFF, 8'h80, p, c); chk("R2 FF*80", p, 255 * 128);
        chk("R5 80 latency", c, exp_lat(8'h80));
        run_mul(8'h00, 8'hFF, p, c); chk("R2 0*FF", p, 0);
        run_mul(8'hFF, 8'h00, p, c); chk("R6 zero product", p, 0);
        chk("R6 zero latency", c, 2);
        run_mul(8'h01, 8'h01, p, c); chk("R5 1*1 latency", c, 6);
    endtask

    task automatic t_sweep_mplier(input logic [W-1:0] a);
        int p, c;
        for (int b = 0; b < 256; b++) begin
            run_mul(a, W'(b), p, c);
            chk("R2 sweep multiplier", p, int'(a) * b);
            chk("R5 latency by multiplier", c, exp_lat(W'(b)));
        end
    endtask

    task automatic t_sweep_mcand(input logic [W-1:0] b);
        int p, c;
        for (int a = 0; a < 256; a++) begin
            run_mul(W'(a), b, p, c);
            chk("R2 sweep multiplicand", p, a * int'(b));
        end
    endtask

    task automatic t_late_change();
        int c = 1;
        @(negedge clk); opa = 8'd200; opb = 8'd123; go = 1'b1;
        @(negedge clk); go = 1'b0;
        @(negedge clk); opa = 8'd3; opb = 8'd5; c = 2;
        while (!done && c < 100) begin @(negedge clk); c++; end
        chk("R3 late operand change", int'(prod), 200 * 123);
    endtask

    task automatic t_hold();
        int p, c, seen = 0;
        run_mul(8'd77, 8'd99, p, c);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); opa = W'(i); opb = W'(i + 1);
            seen += int'(done);
            chk("R7 prod held", int'(prod), 77 * 99);
        end
        chk("R7 done single cycle", seen, 0);
    endtask

    task automatic t_ignore_go();
        int c = 1, extra = 0;
        @(negedge clk); opa = 8'd250; opb = 8'd201; go = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (3) begin @(negedge clk); c++; end
        opa = 8'd9; opb = 8'd9; go = 1'b1;
        @(negedge clk); go = 1'b0; c++;
        while (!done && c < 100) begin @(negedge clk); c++; end
        chk("R8 result with stray go", int'(prod), 250 * 201);
        chk("R8 latency unchanged", c, exp_lat(8'd201));
        repeat (40) begin @(negedge clk); extra += int'(done); end
        chk("R8 no second operation", extra, 0);
        chk("R8 prod unchanged", int'(prod), 250 * 201);
    endtask

    // Watchdog: an expired timer counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_corners();
        t_sweep_mplier(8'hFF);
        t_sweep_mplier(8'hA5);
        t_sweep_mcand(8'hFF);
        t_sweep_mcand(8'h0B);
        t_late_change();
        t_hold();
        t_ignore_go();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule